// File: doc/BRIEF.md
# Tile Scroll Address Register

This block keeps the scroll and memory-address state of a tile-based video processor. It has two copies of that state. The temporary copy is built up by CPU byte writes to two ports: a scroll port and an address port. The current copy drives the 14-bit video memory address and the fine horizontal pixel offset.

Both write ports share one flip-flop that records whether the next byte is the first or the second of a pair. A status read returns that flip-flop to the first-byte state. The second byte written to the address port copies the whole temporary state into the current state.

The current state then advances by a horizontal step or a vertical step. A data-port access picks one of the two steps through a control input. Render-timing strobes can request either step, or both steps in the same cycle.

Top module: `scroll_addr_reg`

## Requirements
- R1: A synchronous reset clears the current state, the temporary state and the write toggle. After reset `vram_addr` and `fine_x` are 0, and the next port write is treated as a first write.
- R2: An address-port write in the first phase loads `wr_data[3:2]` into the temporary nametable selects (bit 3 is vertical, bit 2 is horizontal) and `wr_data[1:0]` into temporary coarse Y bits 4:3. A write in the second phase loads `wr_data[7:5]` into coarse Y bits 2:0 and `wr_data[4:0]` into coarse X, and in the same cycle copies the full temporary state, fine X included, into the current state.
- R3: A scroll-port write in the first phase loads temporary fine X from `wr_data[2:0]` and temporary coarse X from `wr_data[7:3]`. A write in the second phase loads temporary fine Y from `wr_data[2:0]` and temporary coarse Y from `wr_data[7:3]`. Neither write changes the current state.
- R4: Every write to either port inverts the single shared write toggle.
- R5: `status_rd` returns the toggle to the first-write phase. If it coincides with a write, the write uses the old phase and the toggle still ends cleared.
- R6: A horizontal step adds 1 to coarse X. From 31 it wraps to 0 and inverts the horizontal nametable select.
- R7: A vertical step adds 1 to fine Y while fine Y is below 7. Otherwise it clears fine Y and advances coarse Y.
- R8: When a vertical step rolls fine Y over, coarse Y behaves as follows. At 29 it becomes 0 and the vertical nametable select inverts. At 31 it becomes 0 and the select is kept. Any other value adds 1.
- R9: A `data_acc` strobe performs the vertical step when `inc_down` is 1 and the horizontal step when `inc_down` is 0.
- R10: `rnd_inc_h` and `rnd_inc_v` perform the horizontal and vertical steps. When both are high in the same cycle, both steps apply.
- R11: When any render strobe is high, a coincident `data_acc` strobe is ignored.
- R12: A second-phase address write takes priority over any step in the same cycle.
- R13: `vram_addr` packs the state as {fine Y[1:0], vertical select, horizontal select, coarse Y, coarse X}, from bit 13 down to bit 0. Fine Y bit 2 is not visible in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_scroll | input | 1 | Scroll-port byte write strobe |
| wr_addr | input | 1 | Address-port byte write strobe |
| wr_data | input | 8 | CPU write byte |
| status_rd | input | 1 | Status read strobe; clears the write toggle |
| data_acc | input | 1 | Data-port access strobe |
| inc_down | input | 1 | Step select for data accesses: 1 vertical, 0 horizontal |
| rnd_inc_h | input | 1 | Render horizontal step strobe |
| rnd_inc_v | input | 1 | Render vertical step strobe |
| vram_addr | output | 14 | Current video memory address |
| fine_x | output | 3 | Current fine X pixel offset |

## Verification
The write toggle cannot be read directly. If it is wrong, the wrong byte of the next write pair gets copied, so `vram_addr` shows a different coarse X or coarse Y one cycle after the second address write.

Fine Y bit 2 is not visible in `vram_addr` either. If it is wrong, the error shows only when a vertical step rolls fine Y over: coarse Y and the vertical select then move one step too early or too late. The corner tests step fine Y up to 7 before probing the row 29 and row 31 wraps so that this path is exercised.

A wrong step priority shows one cycle after the strobe, as a change in the wrong field of the address.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int CX_W = 5;
  localparam int CY_W = 5;
  localparam int FY_W = 3;
  localparam int FX_W = 3;
  localparam int BYTE_W = 8;
  localparam int CYL_W = BYTE_W - CX_W;
  localparam int CYH_W = CY_W - CYL_W;
  localparam int STATE_W = FY_W + 2 + CY_W + CX_W;

  typedef struct packed {
    logic [FY_W-1:0] fy;
    logic            nt_y;
    logic            nt_x;
    logic [CY_W-1:0] cy;
    logic [CX_W-1:0] cx;
  } scroll_t;
endpackage

// File: rtl/scroll_port_latch.sv
module scroll_port_latch
  import scroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_scroll,
  input  logic              wr_addr,
  input  logic              status_rd,
  input  logic [BYTE_W-1:0] wr_data,
  output scroll_t           tmp_q,
  output scroll_t           tmp_d,
  output logic [FX_W-1:0]   fx_d,
  output logic              tog_q,
  output logic              load_cur
);
  logic [FX_W-1:0] fx_q;
  logic            tog_d;

  always_comb begin
    tmp_d = tmp_q;
    fx_d  = fx_q;
    tog_d = tog_q;
    if (wr_addr) begin
      if (!tog_q) begin
        tmp_d.nt_y                = wr_data[CYH_W+1];
        tmp_d.nt_x                = wr_data[CYH_W];
        tmp_d.cy[CY_W-1:CYL_W]    = wr_data[CYH_W-1:0];
      end else begin
        tmp_d.cy[CYL_W-1:0]       = wr_data[BYTE_W-1:CX_W];
        tmp_d.cx                  = wr_data[CX_W-1:0];
      end
      tog_d = ~tog_q;
    end else if (wr_scroll) begin
      if (!tog_q) begin
        fx_d     = wr_data[FX_W-1:0];
        tmp_d.cx = wr_data[BYTE_W-1:FX_W];
      end else begin
        tmp_d.fy = wr_data[FY_W-1:0];
        tmp_d.cy = wr_data[BYTE_W-1:FY_W];
      end
      tog_d = ~tog_q;
    end
    if (status_rd) tog_d = 1'b0;
  end

  assign load_cur = wr_addr & tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q <= '0;
      fx_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      tmp_q <= tmp_d;
      fx_q  <= fx_d;
      tog_q <= tog_d;
    end
  end
endmodule

// File: rtl/scroll_stepper.sv
module scroll_stepper
  import scroll_pkg::*;
#(
  parameter int ROW_WRAP = 29
) (
  input  scroll_t cur,
  input  logic    do_h,
  input  logic    do_v,
  output scroll_t nxt
);
  localparam logic [CX_W-1:0] CX_MAX = '1;
  localparam logic [CY_W-1:0] CY_MAX = '1;
  localparam logic [FY_W-1:0] FY_MAX = '1;
  localparam logic [CY_W-1:0] CY_FLIP = CY_W'(ROW_WRAP);

  always_comb begin
    nxt = cur;
    if (do_h) begin
      if (cur.cx == CX_MAX) begin
        nxt.cx   = '0;
        nxt.nt_x = ~cur.nt_x;
      end else begin
        nxt.cx = cur.cx + 1'b1;
      end
    end
    if (do_v) begin
      if (cur.fy != FY_MAX) begin
        nxt.fy = cur.fy + 1'b1;
      end else begin
        nxt.fy = '0;
        if (cur.cy == CY_FLIP) begin
          nxt.cy   = '0;
          nxt.nt_y = ~cur.nt_y;
        end else if (cur.cy == CY_MAX) begin
          nxt.cy = '0;
        end else begin
          nxt.cy = cur.cy + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scroll_addr_reg.sv
module scroll_addr_reg
  import scroll_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int ROW_WRAP = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_scroll,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              status_rd,
  input  logic              data_acc,
  input  logic              inc_down,
  input  logic              rnd_inc_h,
  input  logic              rnd_inc_v,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [FX_W-1:0]   fine_x
);
  scroll_t         tmp_q;
  scroll_t         tmp_d;
  scroll_t         cur_q;
  scroll_t         cur_nxt;
  logic [FX_W-1:0] fx_d;
  logic            tog_q;
  logic            load_cur;
  logic            rnd_any;
  logic            do_h;
  logic            do_v;

  scroll_port_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .wr_scroll(wr_scroll),
    .wr_addr  (wr_addr),
    .status_rd(status_rd),
    .wr_data  (wr_data),
    .tmp_q    (tmp_q),
    .tmp_d    (tmp_d),
    .fx_d     (fx_d),
    .tog_q    (tog_q),
    .load_cur (load_cur)
  );

  // Render strobes own the step path whenever either is present.
  assign rnd_any = rnd_inc_h | rnd_inc_v;
  assign do_h    = rnd_any ? rnd_inc_h : (data_acc & ~inc_down);
  assign do_v    = rnd_any ? rnd_inc_v : (data_acc &  inc_down);

  scroll_stepper #(.ROW_WRAP(ROW_WRAP)) u_step (
    .cur (cur_q),
    .do_h(do_h),
    .do_v(do_v),
    .nxt (cur_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      fine_x <= '0;
    end else if (load_cur) begin
      cur_q  <= tmp_d;
      fine_x <= fx_d;
    end else begin
      cur_q  <= cur_nxt;
    end
  end

  assign vram_addr = cur_q[ADDR_W-1:0];
endmodule

// File: rtl/scroll_addr_chk.sv
module scroll_addr_chk
  import scroll_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int ROW_WRAP = 29
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_scroll,
  input logic              wr_addr,
  input logic [7:0]        wr_data,
  input logic              status_rd,
  input logic              data_acc,
  input logic              rnd_inc_h,
  input logic              rnd_inc_v,
  input logic [ADDR_W-1:0] vram_addr,
  input logic              tog,
  input scroll_t           cur
);
  localparam logic [CY_W-1:0] CY_FLIP = CY_W'(ROW_WRAP);
  logic copy;
  assign copy = wr_addr & tog;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vram_addr == '0));

  assert_copy_R2: assert property (@(posedge clk) disable iff (rst)
    copy |=> (vram_addr[CX_W-1:0] == $past(wr_data[CX_W-1:0])));

  assert_flip_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_addr || wr_scroll) && !status_rd) |=> (tog != $past(tog)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> !tog);

  assert_hstep_R6: assert property (@(posedge clk) disable iff (rst)
    (rnd_inc_h && !copy && (cur.cx != '1)) |=> (cur.cx == $past(cur.cx) + 1'b1));

  assert_wrap29_R8: assert property (@(posedge clk) disable iff (rst)
    (rnd_inc_v && !copy && (cur.fy == '1) && (cur.cy == CY_FLIP))
      |=> ((cur.cy == '0) && (cur.nt_y != $past(cur.nt_y))));

  assert_wrap31_R8: assert property (@(posedge clk) disable iff (rst)
    (rnd_inc_v && !copy && (cur.fy == '1) && (cur.cy == '1))
      |=> ((cur.cy == '0) && (cur.nt_y == $past(cur.nt_y))));

  assert_prio_R11: assert property (@(posedge clk) disable iff (rst)
    (rnd_inc_h && !rnd_inc_v && data_acc && !copy)
      |=> ((cur.fy == $past(cur.fy)) && (cur.cy == $past(cur.cy))));
endmodule

bind scroll_addr_reg scroll_addr_chk #(.ADDR_W(ADDR_W), .ROW_WRAP(ROW_WRAP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_scroll(wr_scroll),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .status_rd(status_rd),
  .data_acc (data_acc),
  .rnd_inc_h(rnd_inc_h),
  .rnd_inc_v(rnd_inc_v),
  .vram_addr(vram_addr),
  .tog      (tog_q),
  .cur      (cur_q)
);

// File: tb/sim_scroll_addr_reg.sv
module sim_scroll_addr_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {op[3:0], data[7:0], expected addr[13:0]}
  // op: 0 scroll wr, 1 addr wr, 2 status, 3 data h, 4 data v, 5 rnd h, 6 rnd v, 7 rnd both
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd1, 8'h03, 14'h0000}, {4'd1, 8'hC5, 14'h03C5}, {4'd3, 8'h00, 14'h03C6},
    {4'd4, 8'h00, 14'h13C6}, {4'd6, 8'h00, 14'h23C6}, {4'd6, 8'h00, 14'h33C6},
    {4'd6, 8'h00, 14'h03C6}, {4'd5, 8'h00, 14'h03C7}, {4'd7, 8'h00, 14'h13C8},
    {4'd0, 8'h00, 14'h13C8}, {4'd0, 8'hF2, 14'h13C8}, {4'd1, 8'h0C, 14'h13C8},
    {4'd1, 8'h21, 14'h2C21}, {4'd2, 8'h00, 14'h2C21}
  };

  logic        clk = 1'b0;
  logic        rst, wr_scroll, wr_addr, status_rd, data_acc, inc_down, rnd_inc_h, rnd_inc_v;
  logic [7:0]  wr_data;
  logic [13:0] vram_addr;
  logic [2:0]  fine_x;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scroll_addr_reg u0 (
    .clk(clk), .rst(rst), .wr_scroll(wr_scroll), .wr_addr(wr_addr), .wr_data(wr_data),
    .status_rd(status_rd), .data_acc(data_acc), .inc_down(inc_down),
    .rnd_inc_h(rnd_inc_h), .rnd_inc_v(rnd_inc_v), .vram_addr(vram_addr), .fine_x(fine_x)
  );

  task automatic idle();
    {rst, wr_scroll, wr_addr, status_rd, data_acc, inc_down, rnd_inc_h, rnd_inc_v} = '0;
    wr_data = '0;
  endtask

  // Drive for one clock edge; inputs set and cleared on falling edges.
  task automatic cyc(input logic ws, wa, st, da, dn, rh, rv, input logic [7:0] d);
    @(negedge clk);
    wr_scroll = ws; wr_addr = wa; status_rd = st; data_acc = da; inc_down = dn;
    rnd_inc_h = rh; rnd_inc_v = rv; wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R3 scroll write";
      4'd1: return "R2 address write";
      4'd2: return "R5 status read";
      4'd3: return "R9 data h step";
      4'd4: return "R9 data v step";
      4'd5: return "R10 render h";
      4'd6: return "R7 render v";
      default: return "R10 render both";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    do_reset();
    chk("R1 reset addr", vram_addr, 14'h0000);
    chk("R1 reset fine_x", {11'd0, fine_x}, 14'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] op;
      op = VEC[i][25:22];
      cyc(op == 0, op == 1, op == 2, op == 3 || op == 4, op == 4,
          op == 5 || op == 7, op == 6 || op == 7, VEC[i][21:14]);
      chk(op_tag(op), vram_addr, VEC[i][13:0]);
    end

    // R1: reset mid-activity, toggle back in first phase
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h11);
    do_reset();
    chk("R1 reset after activity", vram_addr, 14'h0000);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h07);
    chk("R1 toggle cleared by reset", vram_addr, 14'h0007);

    // R8: row 29 wrap flips vertical select; R13 fine Y bit 2 hidden
    do_reset();
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h03);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'hA0);
    chk("R2 load row 29", vram_addr, 14'h03A0);
    for (int k = 0; k < 7; k++) cyc(0, 0, 0, 0, 0, 0, 1, 8'h00);
    chk("R13 fine y 7 masked", vram_addr, 14'h33A0);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h00);
    chk("R8 row 29 wrap flips", vram_addr, 14'h0800);

    // R8: row 31 wrap keeps vertical select
    do_reset();
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h0B);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'hFF);
    chk("R2 load row 31", vram_addr, 14'h0BFF);
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0, 0, 1, 8'h00);
    chk("R8 row 31 wrap keeps select", vram_addr, 14'h081F);
    // R6: coarse X 31 wraps and flips horizontal select
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h00);
    chk("R6 coarse x wrap", vram_addr, 14'h0C00);

    // R5: status read clears toggle between writes
    do_reset();
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h11);
    cyc(0, 0, 1, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h02);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h40);
    chk("R5 status clears toggle", vram_addr, 14'h0240);

    // R4/R3: scroll port shares toggle; fine X copied on address pair end
    do_reset();
    cyc(1, 0, 0, 0, 0, 0, 0, 8'h7D);
    chk("R3 scroll write leaves current", {11'd0, fine_x}, 14'd0);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h00);
    chk("R4 shared toggle copy", vram_addr, 14'h0000);
    chk("R3 fine x copied", {11'd0, fine_x}, 14'd5);

    // R11: render strobe wins over data access
    cyc(0, 0, 0, 1, 1, 1, 0, 8'h00);
    chk("R11 render h over data v", vram_addr, 14'h0001);
    cyc(0, 0, 0, 1, 0, 0, 1, 8'h00);
    chk("R11 render v over data h", vram_addr, 14'h1001);

    // R12: copy wins over a coincident step
    do_reset();
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 0, 0, 0, 1, 1, 8'h05);
    chk("R12 copy over step", vram_addr, 14'h0005);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule